// File: doc/BRIEF.md
# Dual-Channel Segmented Converter Digital Front-End

This block is the digital side of a two-channel, 12-bit current-steering converter. The two channels are called I and Q. They have identical data paths and share one clock. Each channel takes an offset-binary word and captures it in an input stage. The word is then split into a coarse 5-bit part and a fine 7-bit part. The coarse part is decoded into 31 equal-weight segment enables in thermometer form. The fine part is kept as 7 binary-weighted enables. Both parts land in an output register that drives a 38-bit switch-control vector for the primary output leg, plus its bitwise inverse for the complementary leg.

For each leg the block also reports a behavioural level value. This is the number of set segments times 128, plus the fine field. The level lets a test compare the output directly with the delayed input code.

A small power state machine handles the sleep input. It has two states, RUN and DOZE:
- RUN to DOZE happens on any rising edge where `sleep_i` is high.
- DOZE to RUN happens on the first rising edge where `sleep_i` is low.
- Reset forces RUN.

In RUN the outputs are live. In DOZE every switch control and every level is held at zero. On any edge where `sleep_i` is high, both pipeline stages keep their contents.

Top module: `dacfe_top`

## Requirements
- R1: A word that is present at rising edge k, with `sleep_i` low at edges k and k+1, shows on the primary level output after edge k+1. So `*_lvl_p` equals that word, read as an unsigned 12-bit number.
- R2: Switch vector bits [37:7] are the segment enables, with bit 7 as segment 0. With N equal to word bits [11:7], exactly segments 0 to N-1 are set and all higher segments are clear.
- R3: Switch vector bits [6:0] equal word bits [6:0].
- R4: While awake, the complementary vector is the bitwise inverse of the primary vector, and `*_lvl_n` equals 4095 minus `*_lvl_p`.
- R5: An all-ones word gives a primary vector of all ones, level 4095 and a complementary vector of zero. An all-zeros word gives the reverse.
- R6: After a rising edge with `sleep_i` high, all four switch vectors and all four levels read zero. The word presented at that edge is discarded.
- R7: At the first edge with `sleep_i` low after sleeping, the output register takes the word held in the input stage from before the sleep. The word presented at that edge is captured as usual.
- R8: A synchronous active-high reset clears both stages to code zero in both channels. Afterwards the primary vectors are zero, the complementary vectors are all ones and `*_lvl_n` is 4095. Reset takes priority over sleep.
- R9: The I and Q channels are independent: each output follows only its own input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Low-power request |
| i_word | input | 12 | I-channel offset-binary input word |
| q_word | input | 12 | Q-channel offset-binary input word |
| i_sw_p | output | 38 | I primary-leg switch controls |
| i_sw_n | output | 38 | I complementary-leg switch controls |
| q_sw_p | output | 38 | Q primary-leg switch controls |
| q_sw_n | output | 38 | Q complementary-leg switch controls |
| i_lvl_p | output | 12 | I primary-leg behavioural level |
| i_lvl_n | output | 12 | I complementary-leg behavioural level |
| q_lvl_p | output | 12 | Q primary-leg behavioural level |
| q_lvl_n | output | 12 | Q complementary-leg behavioural level |

## Verification
The properties assume that `rst`, `sleep_i` and both data words are stable around each rising edge. They also assume that reset is held for at least one edge before any other check applies. The stimulus changes every input only on the falling edge and asserts reset from time zero. The latency property relies on a counter of consecutive waking edges since reset, so the stimulus mixes long awake runs with sleep bursts and a mid-stream reset. This covers both the windows where the property applies and the ones where it is quiet.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    // Power-control states of the front-end
    typedef enum logic {
        PWR_RUN  = 1'b0,
        PWR_DOZE = 1'b1
    } pwr_state_e;

endpackage

// File: rtl/dacfe_therm_dec.sv
module dacfe_therm_dec #(
    parameter int unsigned HI_W = 5
) (
    input  logic [HI_W-1:0]          hi,
    output logic [(1<<HI_W)-2:0]     seg
);
    localparam int unsigned SEG_N = (1 << HI_W) - 1;

    // Segment k is on when the coarse value exceeds k
    for (genvar k = 0; k < SEG_N; k++) begin : g_seg
        assign seg[k] = (hi > HI_W'(k));
    end
endmodule

// File: rtl/dacfe_pwr_fsm.sv
module dacfe_pwr_fsm
    import dacfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    output logic adv,
    output logic out_en
);
    pwr_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            PWR_RUN:  if (sleep_req)  st_nx = PWR_DOZE;
            PWR_DOZE: if (!sleep_req) st_nx = PWR_RUN;
            default:  st_nx = PWR_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= PWR_RUN;
        else     st <= st_nx;
    end

    // Pipeline moves on any waking edge; outputs live only in RUN
    always_comb begin
        adv    = !sleep_req;
        out_en = 1'b0;
        unique case (st)
            PWR_RUN:  out_en = 1'b1;
            PWR_DOZE: out_en = 1'b0;
            default:  out_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/dacfe_lane.sv
module dacfe_lane #(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned HI_W   = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv,
    input  logic                  out_en,
    input  logic [CODE_W-1:0]     word,
    output logic [((1<<HI_W)-1)+(CODE_W-HI_W)-1:0] sw_p,
    output logic [((1<<HI_W)-1)+(CODE_W-HI_W)-1:0] sw_n,
    output logic [CODE_W-1:0]     lvl_p,
    output logic [CODE_W-1:0]     lvl_n
);
    localparam int unsigned LO_W  = CODE_W - HI_W;
    localparam int unsigned SEG_N = (1 << HI_W) - 1;
    localparam int unsigned SW_W  = SEG_N + LO_W;

    logic [CODE_W-1:0] held;   // input stage
    logic [SW_W-1:0]   vec;    // output stage, decoded
    logic [SEG_N-1:0]  seg;
    logic [HI_W-1:0]   cnt_p, cnt_n;

    dacfe_therm_dec #(.HI_W(HI_W)) dec_i (
        .hi  (held[CODE_W-1:LO_W]),
        .seg (seg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            vec  <= '0;
        end else if (adv) begin
            held <= word;
            vec  <= {seg, held[LO_W-1:0]};
        end
    end

    // Behavioural level: segment count weighted by 2^LO_W plus fine field
    always_comb begin
        cnt_p = '0;
        cnt_n = '0;
        for (int k = 0; k < SEG_N; k++) begin
            cnt_p = cnt_p + HI_W'(vec[LO_W+k]);
            cnt_n = cnt_n + HI_W'(!vec[LO_W+k]);
        end
    end

    assign sw_p  = out_en ? vec  : '0;
    assign sw_n  = out_en ? ~vec : '0;
    assign lvl_p = out_en ? {cnt_p, vec[LO_W-1:0]}  : '0;
    assign lvl_n = out_en ? {cnt_n, ~vec[LO_W-1:0]} : '0;
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned HI_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_i,
    input  logic [CODE_W-1:0] i_word,
    input  logic [CODE_W-1:0] q_word,
    output logic [((1<<HI_W)-1)+(CODE_W-HI_W)-1:0] i_sw_p,
    output logic [((1<<HI_W)-1)+(CODE_W-HI_W)-1:0] i_sw_n,
    output logic [((1<<HI_W)-1)+(CODE_W-HI_W)-1:0] q_sw_p,
    output logic [((1<<HI_W)-1)+(CODE_W-HI_W)-1:0] q_sw_n,
    output logic [CODE_W-1:0] i_lvl_p,
    output logic [CODE_W-1:0] i_lvl_n,
    output logic [CODE_W-1:0] q_lvl_p,
    output logic [CODE_W-1:0] q_lvl_n
);
    localparam int unsigned NUM_CH = 2;
    localparam int unsigned SW_W   = ((1 << HI_W) - 1) + (CODE_W - HI_W);

    logic adv, out_en;
    logic [CODE_W-1:0] word_a [NUM_CH];
    logic [SW_W-1:0]   swp_a  [NUM_CH];
    logic [SW_W-1:0]   swn_a  [NUM_CH];
    logic [CODE_W-1:0] lvp_a  [NUM_CH];
    logic [CODE_W-1:0] lvn_a  [NUM_CH];

    dacfe_pwr_fsm pwr_i (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_i),
        .adv       (adv),
        .out_en    (out_en)
    );

    assign word_a[0] = i_word;
    assign word_a[1] = q_word;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        dacfe_lane #(.CODE_W(CODE_W), .HI_W(HI_W)) lane_i (
            .clk    (clk),
            .rst    (rst),
            .adv    (adv),
            .out_en (out_en),
            .word   (word_a[ch]),
            .sw_p   (swp_a[ch]),
            .sw_n   (swn_a[ch]),
            .lvl_p  (lvp_a[ch]),
            .lvl_n  (lvn_a[ch])
        );
    end

    assign i_sw_p  = swp_a[0];
    assign i_sw_n  = swn_a[0];
    assign q_sw_p  = swp_a[1];
    assign q_sw_n  = swn_a[1];
    assign i_lvl_p = lvp_a[0];
    assign i_lvl_n = lvn_a[0];
    assign q_lvl_p = lvp_a[1];
    assign q_lvl_n = lvn_a[1];
endmodule

// File: rtl/dacfe_top_chk.sv
module dacfe_top_chk #(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned HI_W   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep_i,
    input logic [CODE_W-1:0] i_word,
    input logic [CODE_W-1:0] q_word,
    input logic [((1<<HI_W)-1)+(CODE_W-HI_W)-1:0] i_sw_p,
    input logic [((1<<HI_W)-1)+(CODE_W-HI_W)-1:0] i_sw_n,
    input logic [((1<<HI_W)-1)+(CODE_W-HI_W)-1:0] q_sw_p,
    input logic [((1<<HI_W)-1)+(CODE_W-HI_W)-1:0] q_sw_n,
    input logic [CODE_W-1:0] i_lvl_p,
    input logic [CODE_W-1:0] i_lvl_n,
    input logic [CODE_W-1:0] q_lvl_p,
    input logic [CODE_W-1:0] q_lvl_n
);
    localparam int unsigned LO_W  = CODE_W - HI_W;
    localparam int unsigned SEG_N = (1 << HI_W) - 1;
    localparam int unsigned SW_W  = SEG_N + LO_W;
    localparam int          FULL  = (1 << CODE_W) - 1;

    logic       slept;
    logic [1:0] run;
    logic [SEG_N-1:0] seg_i, seg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slept <= 1'b0;
            run   <= 2'd0;
        end else begin
            slept <= sleep_i;
            run   <= sleep_i ? 2'd0 : ((run == 2'd2) ? 2'd2 : run + 2'd1);
        end
    end

    assign seg_i = i_sw_p[SW_W-1:LO_W];
    assign seg_q = q_sw_p[SW_W-1:LO_W];

    // R4
    leg_sum_chk: assert property (@(posedge clk) disable iff (rst)
        !slept |-> ((int'(i_lvl_p) + int'(i_lvl_n) == FULL) &&
                    (int'(q_lvl_p) + int'(q_lvl_n) == FULL)));

    // R4
    leg_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        ((i_sw_p & i_sw_n) == '0) && ((q_sw_p & q_sw_n) == '0));

    // R2
    therm_contig_chk: assert property (@(posedge clk) disable iff (rst)
        (((seg_i + 1'b1) & seg_i) == '0) && (((seg_q + 1'b1) & seg_q) == '0));

    // R6
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> (i_sw_p == '0 && i_sw_n == '0 && q_sw_p == '0 && q_sw_n == '0 &&
                     i_lvl_p == '0 && q_lvl_n == '0));

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (run == 2'd2) |-> (i_lvl_p == $past(i_word, 2) && q_lvl_p == $past(q_word, 2)));
endmodule

bind dacfe_top dacfe_top_chk #(.CODE_W(CODE_W), .HI_W(HI_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .sleep_i (sleep_i),
    .i_word  (i_word),
    .q_word  (q_word),
    .i_sw_p  (i_sw_p),
    .i_sw_n  (i_sw_n),
    .q_sw_p  (q_sw_p),
    .q_sw_n  (q_sw_n),
    .i_lvl_p (i_lvl_p),
    .i_lvl_n (i_lvl_n),
    .q_lvl_p (q_lvl_p),
    .q_lvl_n (q_lvl_n)
);

// File: tb/dacfe_top_tb_top.sv
module dacfe_top_tb_top;
    typedef enum {M_NONE, M_ADV, M_SLP, M_RST} mode_e;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_i = 1'b0;
    logic [11:0] i_word = '0, q_word = '0;
    logic [37:0] i_sw_p, i_sw_n, q_sw_p, q_sw_n;
    logic [11:0] i_lvl_p, i_lvl_n, q_lvl_p, q_lvl_n;

    int    n_chk = 0;
    int    n_err = 0;
    mode_e mode  = M_NONE;
    string ctx   = "R8";
    logic [23:0] sb [$];

    always #4 clk = ~clk;

    dacfe_top dut_i (
        .clk(clk), .rst(rst), .sleep_i(sleep_i), .i_word(i_word), .q_word(q_word),
        .i_sw_p(i_sw_p), .i_sw_n(i_sw_n), .q_sw_p(q_sw_p), .q_sw_n(q_sw_n),
        .i_lvl_p(i_lvl_p), .i_lvl_n(i_lvl_n), .q_lvl_p(q_lvl_p), .q_lvl_n(q_lvl_n)
    );

    function automatic logic [37:0] exp_vec(logic [11:0] w);
        logic [31:0] t;
        t = (32'd1 << w[11:7]) - 32'd1;
        return {t[30:0], w[6:0]};
    endfunction

    task automatic chk(bit ok, string req, logic [37:0] act, logic [37:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_lane(string nm, logic [11:0] w, logic [37:0] sp, logic [37:0] sn,
                            logic [11:0] lp, logic [11:0] ln);
        logic [37:0] ev;
        ev = exp_vec(w);
        chk(sp[37:7] == ev[37:7], {ctx, "/R2 ", nm, " segments"}, sp, ev);
        chk(sp[6:0] == ev[6:0],   {ctx, "/R3 ", nm, " fine bits"}, sp, ev);
        chk(sn == ~ev,            {ctx, "/R4 ", nm, " complement"}, sn, ~ev);
        chk(lp == w,              {ctx, "/R1 ", nm, " level p"}, 38'(lp), 38'(w));
        chk(ln == 12'hFFF - w,    {ctx, "/R4 ", nm, " level n"}, 38'(ln), 38'(12'hFFF - w));
    endtask

    // Monitor: pops the scoreboard after each waking edge and compares
    always @(negedge clk) begin
        case (mode)
            M_ADV, M_RST: begin
                if (mode == M_ADV) void'(sb.pop_front());
                chk_lane("I(R9)", sb[0][23:12], i_sw_p, i_sw_n, i_lvl_p, i_lvl_n);
                chk_lane("Q(R9)", sb[0][11:0],  q_sw_p, q_sw_n, q_lvl_p, q_lvl_n);
            end
            M_SLP: begin
                chk({i_sw_p, i_sw_n} == '0, {ctx, "/R6 I vectors zero"}, i_sw_p | i_sw_n, '0);
                chk({q_sw_p, q_sw_n} == '0, {ctx, "/R6 Q vectors zero"}, q_sw_p | q_sw_n, '0);
                chk({i_lvl_p, i_lvl_n, q_lvl_p, q_lvl_n} == '0, {ctx, "/R6 levels zero"},
                    38'({i_lvl_p, i_lvl_n, q_lvl_p}), '0);
            end
            default: ;
        endcase
        mode = M_NONE;
    end

    // Driver: applies one edge of stimulus and pushes expected items
    task automatic step(logic r, logic s, logic [11:0] a, logic [11:0] b);
        @(negedge clk);
        rst = r; sleep_i = s; i_word = a; q_word = b;
        @(posedge clk);
        if (r) begin
            sb.delete();
            sb.push_back('0);
            sb.push_back('0);
            mode = M_RST;
        end else if (s) begin
            mode = M_SLP;
        end else begin
            sb.push_back({a, b});
            mode = M_ADV;
        end
    endtask

    logic [31:0] rs = 32'h1234_5678;
    function automatic logic [31:0] nxt(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    initial begin
        #(8 * 20000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R8: reset state, reset beats sleep
        ctx = "R8";
        step(1, 0, 12'h5A5, 12'hA5A);
        step(1, 1, 12'hFFF, 12'hFFF);
        // R5: extremes
        ctx = "R5";
        step(0, 0, 12'hFFF, 12'h000);
        step(0, 0, 12'h000, 12'hFFF);
        step(0, 0, 12'hFFF, 12'hFFF);
        step(0, 0, 12'h000, 12'h000);
        // R1: corner codes
        ctx = "R1";
        step(0, 0, 12'h800, 12'h7FF);
        step(0, 0, 12'h07F, 12'h080);
        step(0, 0, 12'hF80, 12'h001);
        step(0, 0, 12'hFFE, 12'h17F);
        // R2: every coarse value, opposite order on Q
        ctx = "R2";
        for (int n = 0; n < 32; n++)
            step(0, 0, {5'(n), 7'h55}, {5'(31 - n), 7'h2A});
        // R9: independent pseudo-random words
        ctx = "R9";
        for (int k = 0; k < 200; k++) begin
            rs = nxt(rs);
            step(0, 0, rs[11:0], rs[27:16]);
        end
        // R6: sleep burst, presented words discarded
        ctx = "R6";
        step(0, 0, 12'h321, 12'hCDE);
        step(0, 0, 12'h456, 12'hBA9);
        for (int k = 0; k < 4; k++) step(0, 1, 12'h0F0 + 12'(k), 12'hF0F - 12'(k));
        // R7: wake resumes from held stage
        ctx = "R7";
        step(0, 0, 12'h9AB, 12'h6C3);
        step(0, 0, 12'h111, 12'hEEE);
        step(0, 1, 12'h222, 12'hDDD);
        step(0, 0, 12'h333, 12'hCCC);
        step(0, 0, 12'h444, 12'hBBB);
        // R8: mid-stream reset
        ctx = "R8";
        step(0, 0, 12'hABC, 12'h123);
        step(1, 0, 12'hDEF, 12'h456);
        step(0, 0, 12'h777, 12'h888);
        step(0, 0, 12'h999, 12'h666);
        step(0, 0, 12'h000, 12'h000);
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule